// File: doc/BRIEF.md
# Sorted Sub-Module Insertion Selector

This block picks which of the half-bridge sub-modules in one converter arm are inserted and which are bypassed. The modulator supplies a requested level, meaning the number of sub-modules to insert, and a strobe. The block also receives one bit for the arm current direction and a capacitor voltage for each sub-module. When the strobe arrives with a level that differs from the one in force, the block ranks the capacitors by voltage. If the current is discharging the capacitors, the fullest ones are inserted. If the current is charging them, the emptiest ones are inserted. Between level changes the insertion pattern does not move, so each sub-module switches at most once per level transition.

Two protection paths override the pattern. The first is an overvoltage trip on any capacitor, which latches. The second is an active-low external fault input, which acts at once and does not latch. Either one forces every sub-module into bypass. The selection logic keeps working underneath while the overrides are active. When the override is removed, the most recent pattern appears on the outputs.

Top module: `smod_insert_sel`

## Requirements
- R1: With `cur_chg`=0 (discharging), a new selection inserts the `cnt` sub-modules that have the highest capacitor voltages.
- R2: With `cur_chg`=1 (charging), a new selection inserts the `cnt` sub-modules that have the lowest capacitor voltages.
- R3: When voltages are equal, the sub-module with the lower index wins. Index k is `vcap[k*12 +: 12]` and is driven to `ins_out[k]`.
- R4: The insert count equals `lvl_req` for values 0 to 4. Values 5 to 7 saturate to 4, and that saturated value is the one compared for a change.
- R5: A selection is made only on a cycle where `lvl_stb`=1 and the saturated level differs from the level last accepted. In every other case, including a strobe with unchanged level and a level change without a strobe, the pattern is held.
- R6: A new pattern appears on all bits of `ins_out` at the same clock edge, which is the second rising edge after the strobe cycle is sampled. Before that edge the old pattern is still visible.
- R7: If any capacitor voltage is strictly greater than `OV_LIM` (default 3800), `bypass_all` goes to 1 and `ins_out` goes to 0 from the next rising edge. A voltage equal to `OV_LIM` does not trip.
- R8: The overvoltage trip stays latched after the voltage recovers. It is released only by reset or by a cycle with `ovp_clr`=1, and after release the held pattern reappears.
- R9: While `fault_n`=0, `bypass_all`=1 and `ins_out`=0 in the same cycle, without waiting for a clock edge. After release the held pattern returns.
- R10: After reset, `ins_out`=0, `bypass_all`=0 (with `fault_n`=1), and the accepted level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_req | input | 3 | Requested inserted count |
| lvl_stb | input | 1 | Level-change strobe |
| cur_chg | input | 1 | 1 = arm current charges capacitors |
| vcap | input | 48 | Four 12-bit unsigned capacitor voltages, index 0 in the low bits |
| fault_n | input | 1 | Active-low external fault |
| ovp_clr | input | 1 | Clears the latched overvoltage trip |
| ins_out | output | 4 | 1 = sub-module inserted |
| bypass_all | output | 1 | 1 = all sub-modules forced to bypass |

## Verification
Four properties are checked by assertions on every cycle. The pattern holds whenever no selection is pending. A completed selection inserts exactly the accepted count. Any overvoltage sets the trip, which then stays set until cleared. A low fault input blanks the outputs. The remaining behaviours can only be shown by the bench scenarios, because each one needs a reference ranking computed independently: which sub-modules a given ordering picks in each current direction, tie-breaking, level saturation, the exact two-edge latency, the `OV_LIM` boundary, and the pattern returning after a trip or fault is released.

// File: rtl/smsel_pkg.sv
package smsel_pkg;
    typedef enum logic {
        DIR_DISCHARGE = 1'b0,
        DIR_CHARGE    = 1'b1
    } cur_dir_e;
endpackage

// File: rtl/smsel_rank.sv
// Rank of each sub-module in the active ordering: 0 = inserted first.
module smsel_rank
    import smsel_pkg::*;
#(
    parameter int N  = 4,
    parameter int VW = 12,
    parameter int CW = 3
) (
    input  logic [N*VW-1:0] vcap,
    input  cur_dir_e        dir,
    output logic [N*CW-1:0] rank_flat
);
    for (genvar gi = 0; gi < N; gi++) begin : g_rank
        logic [CW-1:0] rk;
        always_comb begin
            rk = '0;
            for (int j = 0; j < N; j++) begin
                if (j != gi) begin
                    logic [VW-1:0] vi;
                    logic [VW-1:0] vj;
                    logic          ahead;
                    vi = vcap[gi*VW +: VW];
                    vj = vcap[j*VW +: VW];
                    ahead = (dir == DIR_CHARGE) ? (vj < vi) : (vj > vi);
                    if (ahead || (vj == vi && j < gi)) begin
                        rk = rk + CW'(1);
                    end
                end
            end
        end
        assign rank_flat[gi*CW +: CW] = rk;
    end
endmodule

// File: rtl/smsel_ovp.sv
// Latched overvoltage trip across all capacitors.
module smsel_ovp #(
    parameter int          N      = 4,
    parameter int          VW     = 12,
    parameter logic [11:0] OV_LIM = 12'd3800
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N*VW-1:0] vcap,
    input  logic            clr,
    output logic            trip_q
);
    logic any_hi;
    logic trip_d;

    always_comb begin
        any_hi = 1'b0;
        for (int k = 0; k < N; k++) begin
            if (vcap[k*VW +: VW] > VW'(OV_LIM)) begin
                any_hi = 1'b1;
            end
        end
        trip_d = clr ? 1'b0 : (trip_q | any_hi);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trip_q <= 1'b0;
        end else begin
            trip_q <= trip_d;
        end
    end

    assert_trip_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (any_hi && !clr) |=> trip_q);

    assert_trip_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_q && !clr) |=> trip_q);
endmodule

// File: rtl/smod_insert_sel.sv
module smod_insert_sel
    import smsel_pkg::*;
#(
    parameter int          N      = 4,
    parameter int          VW     = 12,
    parameter int          LVLW   = 3,
    parameter logic [11:0] OV_LIM = 12'd3800
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [LVLW-1:0] lvl_req,
    input  logic            lvl_stb,
    input  logic            cur_chg,
    input  logic [N*VW-1:0] vcap,
    input  logic            fault_n,
    input  logic            ovp_clr,
    output logic [N-1:0]    ins_out,
    output logic            bypass_all
);
    localparam int CW = $clog2(N + 1);

    typedef struct packed {
        logic            pend;
        logic [CW-1:0]   cnt;
        logic [CW-1:0]   lvl;
        logic [N*CW-1:0] rank;
        logic [N-1:0]    ins;
    } sel_st_t;

    sel_st_t         st_d, st_q;
    logic [N*CW-1:0] rank_w;
    logic [CW-1:0]   lvl_sat;
    logic            trip_q;
    cur_dir_e        dir_w;

    assign dir_w = cur_dir_e'(cur_chg);

    smsel_rank #(.N(N), .VW(VW), .CW(CW)) i_rank (
        .vcap      (vcap),
        .dir       (dir_w),
        .rank_flat (rank_w)
    );

    smsel_ovp #(.N(N), .VW(VW), .OV_LIM(OV_LIM)) i_ovp (
        .clk    (clk),
        .rst_n  (rst_n),
        .vcap   (vcap),
        .clr    (ovp_clr),
        .trip_q (trip_q)
    );

    always_comb begin
        lvl_sat = (int'(lvl_req) > N) ? CW'(N) : CW'(lvl_req);
        st_d      = st_q;
        st_d.pend = 1'b0;
        if (lvl_stb && lvl_sat != st_q.lvl) begin
            st_d.pend = 1'b1;
            st_d.cnt  = lvl_sat;
            st_d.lvl  = lvl_sat;
            st_d.rank = rank_w;
        end
        if (st_q.pend) begin
            for (int k = 0; k < N; k++) begin
                st_d.ins[k] = st_q.rank[k*CW +: CW] < st_q.cnt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bypass_all = trip_q | ~fault_n;
    assign ins_out    = st_q.ins & ~{N{bypass_all}};

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.pend |=> $stable(st_q.ins));

    assert_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |=> ($countones(st_q.ins) == int'($past(st_q.cnt))));

    assert_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |-> (ins_out == '0));
endmodule

// File: tb/test_smod_insert_sel.sv
module test_smod_insert_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  lvl_req = '0;
    logic        lvl_stb = 1'b0;
    logic        cur_chg = 1'b0;
    logic [11:0] vb [4];
    logic        fault_n = 1'b1;
    logic        ovp_clr = 1'b0;
    logic [3:0]  ins_out;
    logic        bypass_all;
    logic [47:0] vcap;

    int total = 0;
    int bad = 0;
    logic [3:0] exp_ins = '0;
    int exp_lvl = 0;

    always #5 clk = ~clk;
    assign vcap = {vb[3], vb[2], vb[1], vb[0]};

    smod_insert_sel i_smod_insert_sel (
        .clk(clk), .rst_n(rst_n), .lvl_req(lvl_req), .lvl_stb(lvl_stb),
        .cur_chg(cur_chg), .vcap(vcap), .fault_n(fault_n), .ovp_clr(ovp_clr),
        .ins_out(ins_out), .bypass_all(bypass_all)
    );

    function automatic logic [3:0] pick(input logic chg, input int cnt);
        logic [3:0] taken = '0;
        for (int n = 0; n < cnt; n++) begin
            int best = -1;
            for (int j = 0; j < 4; j++) begin
                if (!taken[j]) begin
                    if (best < 0) best = j;
                    else if (chg ? (vb[j] < vb[best]) : (vb[j] > vb[best])) best = j;
                end
            end
            taken[best] = 1'b1;
        end
        return taken;
    endfunction

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Strobe a level with given direction; model update; wait to the edge where the pattern lands.
    task automatic strobe(input logic [2:0] lv, input logic chg);
        int c;
        @(negedge clk);
        lvl_req = lv; cur_chg = chg; lvl_stb = 1'b1;
        c = (lv > 4) ? 4 : int'(lv);
        if (c != exp_lvl) begin
            exp_lvl = c;
            exp_ins = pick(chg, c);
        end
        @(negedge clk);
        lvl_stb = 1'b0;
        @(posedge clk);
        #1;
    endtask

    task automatic setv(input int a, input int b, input int c, input int d);
        vb[0] = 12'(a); vb[1] = 12'(b); vb[2] = 12'(c); vb[3] = 12'(d);
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        setv(1000, 1000, 1000, 1000);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R10 reset ins", ins_out, 4'b0000);
        chk("R10 reset bypass", {3'b0, bypass_all}, 4'b0000);

        // R1 discharge ordering
        setv(1200, 2400, 900, 1800);
        strobe(3'd2, 1'b0);
        chk("R1 discharge top2", ins_out, exp_ins);
        chk("R1 discharge literal", ins_out, 4'b1010);
        // R2 charge ordering
        strobe(3'd1, 1'b1);
        chk("R2 charge lowest", ins_out, 4'b0100);
        // R3 ties
        setv(2000, 2000, 2000, 2000);
        strobe(3'd2, 1'b0);
        chk("R3 tie discharge", ins_out, 4'b0011);
        strobe(3'd3, 1'b1);
        chk("R3 tie charge", ins_out, 4'b0111);
        setv(1500, 3000, 1500, 3000);
        strobe(3'd1, 1'b0);
        chk("R3 tie pair", ins_out, 4'b0010);

        // R5 hold: same level with new voltages
        setv(3000, 100, 200, 300);
        strobe(3'd1, 1'b0);
        chk("R5 same level held", ins_out, 4'b0010);
        // R5 level change without strobe
        @(negedge clk); lvl_req = 3'd3;
        repeat (3) @(posedge clk);
        #1;
        chk("R5 no strobe held", ins_out, 4'b0010);

        // R4 saturation
        strobe(3'd0, 1'b0);
        chk("R4 level zero", ins_out, 4'b0000);
        strobe(3'd7, 1'b1);
        chk("R4 saturate 7", ins_out, 4'b1111);
        strobe(3'd4, 1'b0);
        chk("R4 4 equals saturated", ins_out, 4'b1111);

        // R6 latency and atomic update
        setv(100, 200, 300, 400);
        @(negedge clk); lvl_req = 3'd2; cur_chg = 1'b0; lvl_stb = 1'b1;
        @(posedge clk); #1;
        chk("R6 old after first edge", ins_out, 4'b1111);
        @(negedge clk); lvl_stb = 1'b0;
        @(posedge clk); #1;
        chk("R6 new after second edge", ins_out, 4'b1100);
        exp_lvl = 2; exp_ins = 4'b1100;

        // R7 boundary
        @(negedge clk); vb[2] = 12'd3800;
        repeat (2) @(posedge clk); #1;
        chk("R7 equal no trip", {3'b0, bypass_all}, 4'b0000);
        @(negedge clk); vb[2] = 12'd3801;
        @(posedge clk); #1;
        chk("R7 trip bypass", {3'b0, bypass_all}, 4'b0001);
        chk("R7 trip ins", ins_out, 4'b0000);
        // R8 latch
        @(negedge clk); vb[2] = 12'd300;
        repeat (3) @(posedge clk); #1;
        chk("R8 latched", {3'b0, bypass_all}, 4'b0001);
        @(negedge clk); ovp_clr = 1'b1;
        @(posedge clk); #1;
        @(negedge clk); ovp_clr = 1'b0;
        #1;
        chk("R8 released bypass", {3'b0, bypass_all}, 4'b0000);
        chk("R8 pattern back", ins_out, 4'b1100);

        // R9 external fault
        @(negedge clk); fault_n = 1'b0;
        #1;
        chk("R9 fault bypass", {3'b0, bypass_all}, 4'b0001);
        chk("R9 fault ins", ins_out, 4'b0000);
        @(negedge clk); fault_n = 1'b1;
        #1;
        chk("R9 fault release", ins_out, 4'b1100);

        // Random mix over R1 R2 R4
        for (int it = 0; it < 80; it++) begin
            for (int k = 0; k < 4; k++) vb[k] = 12'($urandom_range(3800, 0));
            if ($urandom_range(3, 0) == 0) vb[$urandom_range(3, 0)] = vb[0];
            strobe(3'($urandom_range(7, 0)), 1'($urandom_range(1, 0)));
            chk("R1 R2 R4 random", ins_out, exp_ins);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule